// File: doc/BRIEF.md
# Clear-on-Read Interrupt Flag Register

This block keeps the interrupt flags of a radio transceiver's host interface in one 8-bit register. Single-cycle event pulses from the radio core set individual flags: regulator up, ready reached, idle reached, soft calibration warning and hard calibration failure. A host read of the register returns the flags and clears every flag in the same step. Firmware must therefore keep its own copy of anything it still needs.

A single interrupt request line combines the flags. Four flags pass through a host-supplied enable mask. The regulator flag has no enable. Instead it is held back until the power-domain reset has been released for one clock edge. There are two resets. The power-domain reset sets the regulator flag. The external reset pin clears only the other flags and leaves the regulator flag alone.

The read interface is a plain strobe with an address and has no back-pressure. A read that matches the register address returns its data one cycle after the strobe. The block never stalls and never refuses a read. The host side has no write path, so this register cannot be written.

Top module: `radio_irq_flags`

## Requirements
- R1: While the power-domain reset `rst_pwr_n` is low, the stored flags take the value 0x80, `rd_data` is 0 and `irq` is 0.
- R2: After `rst_pwr_n` rises, from the first clock edge on, bit 7 (regulator flag) drives `irq` high whatever `irq_en` holds. Bit 7 clears only through a read, and `ev_vreg_up` sets it again.
- R3: A read with `rd_en`=1 and `rd_addr`=0x04 puts the flag byte in `rd_data` on the next cycle, and all flags are 0 afterwards. That byte is the flags as they stood before that clock edge.
- R4: An event pulse that arrives in the same cycle as a clearing read is absent from that read's data. Its flag is set after the clear, so the next read returns it.
- R5: Bit 5 (ready) is set by any one of `ev_cal_done`, `ev_init_done` or `ev_xtal_ramped`.
- R6: Bit 4 (idle) is set by `ev_idle` only when `idle_by_host` is 0 in the same cycle. An idle entry that the host caused leaves the flag unchanged.
- R7: Bit 2 is set by `ev_cal_soft` and bit 1 is set by `ev_cal_hard`.
- R8: Bits 6, 3 and 0 of `rd_data` always read 0.
- R9: `irq` equals the OR of flag bits 5, 4, 2 and 1, each ANDed with the same bit of `irq_en`, ORed with bit 7 once the gating of R2 has released. Bits 7, 6, 3 and 0 of `irq_en` have no effect.
- R10: While `rst_ext_n` is low and `rst_pwr_n` is high, flag bits 5, 4, 2 and 1 clear, bit 7 holds its value, events and reads are ignored, and `rd_data` is 0.
- R11: A read strobe at any address other than 0x04 clears nothing, and `rd_data` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pwr_n | input | 1 | Power-domain reset, active low, synchronous |
| rst_ext_n | input | 1 | External reset pin, active low, synchronous |
| ev_vreg_up | input | 1 | Regulator came up |
| ev_cal_done | input | 1 | Calibration finished |
| ev_init_done | input | 1 | Initialization finished |
| ev_xtal_ramped | input | 1 | Crystal ramp-up finished |
| ev_idle | input | 1 | Idle state entered |
| idle_by_host | input | 1 | Host caused the current idle entry |
| ev_cal_soft | input | 1 | Recalibration advised |
| ev_cal_hard | input | 1 | Recalibration mandatory |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| irq_en | input | 8 | Enable mask, bit positions match the flags |
| rd_data | output | 8 | Read data, one cycle after the strobe |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a read that collides with events in the same clock. In that cycle the returned byte must leave the new events out, while the register must keep them. A second hard case is the interaction of the two resets with the gate on the regulator flag. Directed sequences set up each collision on purpose, and an external reset is asserted while the regulator flag is still pending. A long random run then drives reads at random, often at the matching address, together with dense event pulses and a changing mask. A bench model predicts `rd_data` and `irq` on every cycle.

// File: rtl/radio_irq_flags_pkg.sv
package radio_irq_flags_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned B_VREG   = 7;
  localparam int unsigned B_READY  = 5;
  localparam int unsigned B_IDLE   = 4;
  localparam int unsigned B_CSOFT  = 2;
  localparam int unsigned B_CHARD  = 1;
  // flags that pass through the enable mask
  localparam logic [FLAG_W-1:0] MASKABLE = (FLAG_W'(1) << B_READY) | (FLAG_W'(1) << B_IDLE)
                                         | (FLAG_W'(1) << B_CSOFT) | (FLAG_W'(1) << B_CHARD);
  localparam logic [FLAG_W-1:0] NONMASK  = FLAG_W'(1) << B_VREG;
  localparam logic [FLAG_W-1:0] LIVE     = MASKABLE | NONMASK;

  typedef struct packed {
    logic vreg_up;
    logic cal_done;
    logic init_done;
    logic xtal_ramped;
    logic idle;
    logic idle_by_host;
    logic cal_soft;
    logic cal_hard;
  } evt_t;
endpackage

// File: rtl/radio_irq_event_merge.sv
module radio_irq_event_merge
  import radio_irq_flags_pkg::*;
(
  input  evt_t              evt,
  output logic [FLAG_W-1:0] set_vec
);
  always_comb begin
    set_vec          = '0;
    set_vec[B_VREG]  = evt.vreg_up;
    set_vec[B_READY] = evt.cal_done | evt.init_done | evt.xtal_ramped;
    set_vec[B_IDLE]  = evt.idle & ~evt.idle_by_host;
    set_vec[B_CSOFT] = evt.cal_soft;
    set_vec[B_CHARD] = evt.cal_hard;
  end
endmodule

// File: rtl/radio_irq_flag_store.sv
module radio_irq_flag_store
  import radio_irq_flags_pkg::*;
#(
  parameter int unsigned W = FLAG_W,
  parameter logic [W-1:0] IMPL     = LIVE,
  parameter logic [W-1:0] PWR_VAL  = NONMASK,
  parameter logic [W-1:0] EXT_KEEP = NONMASK
) (
  input  logic         clk,
  input  logic         rst_pwr_n,
  input  logic         rst_ext_n,
  input  logic         rd_hit,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] flags,
  output logic [W-1:0] rd_data
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_pwr_n)      q <= PWR_VAL[i];
        else if (!rst_ext_n) q <= EXT_KEEP[i] ? q : 1'b0;
        else                 q <= (q & ~rd_hit) | set_vec[i];
      end
      assign flags[i] = q;
    end else begin : g_rsv
      assign flags[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_pwr_n || !rst_ext_n) rd_data <= '0;
    else                          rd_data <= rd_hit ? flags : '0;
  end

  // R3: a read with no event in that cycle leaves every flag clear
  a_r3_clear_after_read: assert property (@(posedge clk) disable iff (!rst_pwr_n || !rst_ext_n)
    (rd_hit && set_vec == '0) |=> (flags == '0));
  // R8: reserved positions never appear in read data
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    ((rd_data & ~IMPL) == '0));
endmodule

// File: rtl/radio_irq_req_gen.sv
module radio_irq_req_gen
  import radio_irq_flags_pkg::*;
(
  input  logic              clk,
  input  logic              rst_pwr_n,
  input  logic [FLAG_W-1:0] flags,
  input  logic [FLAG_W-1:0] irq_en,
  output logic              irq
);
  logic gate_open;

  always_ff @(posedge clk) begin
    if (!rst_pwr_n) gate_open <= 1'b0;
    else            gate_open <= 1'b1;
  end

  assign irq = (|(flags & irq_en & MASKABLE)) | (|(flags & NONMASK) & gate_open);

  // R1: no request while the power domain is held in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_pwr_n |=> (!rst_pwr_n -> !irq));
  // R2: a pending regulator flag requests once gating has opened
  a_r2_vreg_unmasked: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    ($past(rst_pwr_n) && flags[B_VREG]) |-> irq);
endmodule

// File: rtl/radio_irq_flags.sv
module radio_irq_flags
  import radio_irq_flags_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rst_pwr_n,
  input  logic              rst_ext_n,
  input  logic              ev_vreg_up,
  input  logic              ev_cal_done,
  input  logic              ev_init_done,
  input  logic              ev_xtal_ramped,
  input  logic              ev_idle,
  input  logic              idle_by_host,
  input  logic              ev_cal_soft,
  input  logic              ev_cal_hard,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [FLAG_W-1:0] irq_en,
  output logic [FLAG_W-1:0] rd_data,
  output logic              irq
);
  evt_t              evt;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] flags;
  logic              rd_hit;

  assign evt = '{vreg_up: ev_vreg_up, cal_done: ev_cal_done, init_done: ev_init_done,
                 xtal_ramped: ev_xtal_ramped, idle: ev_idle, idle_by_host: idle_by_host,
                 cal_soft: ev_cal_soft, cal_hard: ev_cal_hard};
  assign rd_hit = rd_en && (rd_addr == REG_ADDR);

  radio_irq_event_merge u_merge (.evt(evt), .set_vec(set_vec));

  radio_irq_flag_store #(.W(FLAG_W)) u_store (
    .clk(clk), .rst_pwr_n(rst_pwr_n), .rst_ext_n(rst_ext_n), .rd_hit(rd_hit),
    .set_vec(set_vec), .flags(flags), .rd_data(rd_data));

  radio_irq_req_gen u_req (
    .clk(clk), .rst_pwr_n(rst_pwr_n), .flags(flags), .irq_en(irq_en), .irq(irq));

  // R6: a host-caused idle entry cannot raise a clear idle flag
  a_r6_host_idle_filtered: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    (!flags[B_IDLE] && ev_idle && idle_by_host) |=> !flags[B_IDLE]);
  // R7: a hard calibration event is stored in bit 1
  a_r7_hard_stored: assert property (@(posedge clk) disable iff (!rst_pwr_n || !rst_ext_n)
    ev_cal_hard |=> flags[B_CHARD]);
  // R10: external reset leaves the regulator flag as it was
  a_r10_ext_keeps_vreg: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    !rst_ext_n |=> $stable(flags[B_VREG]));
  // R11: a read elsewhere returns zero
  a_r11_other_addr: assert property (@(posedge clk) disable iff (!rst_pwr_n || !rst_ext_n)
    (rd_en && rd_addr != REG_ADDR) |=> (rd_data == '0));
endmodule

// File: tb/radio_irq_flags_tb_top.sv
module radio_irq_flags_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_pwr_n, rst_ext_n;
  logic ev_vreg_up, ev_cal_done, ev_init_done, ev_xtal_ramped;
  logic ev_idle, idle_by_host, ev_cal_soft, ev_cal_hard;
  logic rd_en;
  logic [7:0] rd_addr, irq_en, rd_data;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_irq_flags dut_i (
    .clk(clk), .rst_pwr_n(rst_pwr_n), .rst_ext_n(rst_ext_n),
    .ev_vreg_up(ev_vreg_up), .ev_cal_done(ev_cal_done), .ev_init_done(ev_init_done),
    .ev_xtal_ramped(ev_xtal_ramped), .ev_idle(ev_idle), .idle_by_host(idle_by_host),
    .ev_cal_soft(ev_cal_soft), .ev_cal_hard(ev_cal_hard),
    .rd_en(rd_en), .rd_addr(rd_addr), .irq_en(irq_en), .rd_data(rd_data), .irq(irq));

  int total = 0, bad = 0;
  logic [7:0] m_flags = 8'h80, m_rd = 8'h00;
  bit m_gate = 1'b0, m_valid = 1'b0;

  // expected set bits; ev: 0 vreg,1 cal_done,2 init,3 xtal,4 idle,5 host,6 soft,7 hard
  function automatic logic [7:0] exp_set(input logic [7:0] ev);
    logic [7:0] s = 8'h00;
    s[7] = ev[0];
    s[5] = ev[1] | ev[2] | ev[3];
    s[4] = ev[4] & ~ev[5];
    s[2] = ev[6];
    s[1] = ev[7];
    return s;
  endfunction

  function automatic logic exp_irq(input logic [7:0] f, input logic [7:0] en, input bit g);
    return (|(f & en & 8'h36)) | (f[7] & g);
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // check outputs from the previous edge, then drive the next cycle and advance the model
  task automatic step(input string tag, input bit pwr, input bit ext, input bit rd,
                      input logic [7:0] addr, input logic [7:0] en, input logic [7:0] ev);
    bit hit;
    @(negedge clk);
    if (m_valid) begin
      chk(tag, "rd_data", rd_data, m_rd);
      chk("R8", "reserved bits", rd_data & 8'h49, 8'h00);
      chk(tag, "irq", {7'd0, irq}, {7'd0, exp_irq(m_flags, irq_en, m_gate)});
    end
    rst_pwr_n = pwr; rst_ext_n = ext; rd_en = rd; rd_addr = addr; irq_en = en;
    {ev_cal_hard, ev_cal_soft, idle_by_host, ev_idle, ev_xtal_ramped, ev_init_done, ev_cal_done, ev_vreg_up} = ev;
    hit = rd && (addr == 8'h04);
    if (!pwr) begin
      m_flags = 8'h80; m_rd = 8'h00;
    end else if (!ext) begin
      m_flags = m_flags & 8'h80; m_rd = 8'h00;
    end else begin
      m_rd = hit ? m_flags : 8'h00;
      m_flags = (hit ? 8'h00 : m_flags) | exp_set(ev);
    end
    m_gate = pwr;
    m_valid = 1'b1;
  endtask

  task automatic rd4(input string tag, input logic [7:0] en);
    step(tag, 1, 1, 1, 8'h04, en, 8'h00);
  endtask
  task automatic ev1(input string tag, input logic [7:0] ev, input logic [7:0] en);
    step(tag, 1, 1, 0, 8'h00, en, ev);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst_pwr_n = 0; rst_ext_n = 1; rd_en = 0; rd_addr = 0; irq_en = 0;
    {ev_cal_hard, ev_cal_soft, idle_by_host, ev_idle, ev_xtal_ramped, ev_init_done, ev_cal_done, ev_vreg_up} = '0;
    // R1: held in power reset with events and enables active
    step("R1", 0, 1, 0, 8'h00, 8'hFF, 8'hFF);
    step("R1", 0, 1, 1, 8'h04, 8'hFF, 8'hC2);
    step("R1", 0, 1, 0, 8'h00, 8'h00, 8'h00);
    // R2: release with mask zero, regulator flag alone raises irq
    step("R2", 1, 1, 0, 8'h00, 8'h00, 8'h00);
    ev1("R2", 8'h00, 8'h00);
    // R3: read returns 0x80 and clears, second read returns 0
    rd4("R3", 8'h00);
    rd4("R3", 8'h00);
    ev1("R3", 8'h00, 8'h00);
    // R5: each ready source separately
    ev1("R5", 8'h02, 8'h00); rd4("R5", 8'h00);
    ev1("R5", 8'h04, 8'h20); rd4("R5", 8'h20);
    ev1("R5", 8'h08, 8'h20); rd4("R5", 8'h00);
    // R6: host-caused idle filtered, own idle recorded
    ev1("R6", 8'h30, 8'h10); rd4("R6", 8'h10);
    ev1("R6", 8'h10, 8'h10); rd4("R6", 8'h10);
    // R7: soft and hard calibration
    ev1("R7", 8'h40, 8'h04); rd4("R7", 8'h04);
    ev1("R7", 8'h80, 8'h02); rd4("R7", 8'h02);
    // R11: other address keeps flags
    ev1("R11", 8'h82, 8'h00);
    step("R11", 1, 1, 1, 8'h05, 8'h00, 8'h00);
    step("R11", 1, 1, 1, 8'h84, 8'h00, 8'h00);
    rd4("R11", 8'h00);
    // R4: event collides with read
    ev1("R4", 8'h40, 8'h00);
    step("R4", 1, 1, 1, 8'h04, 8'h00, 8'h81);
    rd4("R4", 8'h00);
    ev1("R4", 8'h00, 8'h00);
    // R9: unused enable bits must not pass; walk mask bits
    ev1("R9", 8'hD2, 8'hC9);
    for (int b = 0; b < 8; b++) ev1("R9", 8'h00, 8'h01 << b);
    rd4("R9", 8'hFF);
    // R10: external reset keeps bit 7, drops the rest, ignores events and reads
    ev1("R10", 8'h47, 8'h36);
    step("R10", 1, 0, 1, 8'h04, 8'h36, 8'hFF);
    step("R10", 1, 0, 0, 8'h00, 8'h36, 8'h80);
    ev1("R10", 8'h00, 8'h36);
    rd4("R10", 8'h36);
    ev1("R10", 8'h00, 8'h36);
    // R1: power reset in mid-run returns to 0x80 and closes the gate
    ev1("R1", 8'hC6, 8'hFF);
    step("R1", 0, 1, 0, 8'h00, 8'hFF, 8'h00);
    step("R1", 1, 1, 0, 8'h00, 8'h00, 8'h00);
    rd4("R1", 8'h00);
    // random run
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ev, en, ad;
      bit rd, ext, pwr;
      ev  = 8'($urandom) & 8'($urandom);
      en  = 8'($urandom);
      rd  = ($urandom % 4) == 0;
      ad  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h04;
      ext = ($urandom % 64) != 0;
      pwr = ($urandom % 256) != 0;
      step("R9", pwr, ext, rd, ad, en, ev);
    end
    step("R3", 1, 1, 0, 8'h00, 8'h00, 8'h00);
    step("R3", 1, 1, 0, 8'h00, 8'h00, 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule